// File: doc/BRIEF.md
# Instruction-Fetch Execution Permit Gate

This block decides, cycle by cycle, whether instruction fetches aimed at an on-chip SRAM may proceed. Software holds a 4-bit multibit-coded enable field that is guarded by a lock. While the lock is open the field can be rewritten. A single write of 0 to the lock's bit 0 seals it, and it stays sealed until reset. The field counts only when an 8-bit fuse switch carries its true code. When the fuse switch carries any other value, a multibit lifecycle debug-enable input alone decides whether fetches are allowed.

The resulting permit gates an incoming fetch request. A permitted fetch is forwarded to the memory. A denied fetch is answered with an error pulse instead of data. Any of the three multibit values that is neither its true nor its false code raises an encoding-error flag. A build parameter can remove execution support, which holds the permit low at all times.

The lock is a two-state machine. In LK_OPEN, enable-field writes are accepted. A lock write with bit 0 at 0 takes the transition LK_OPEN to LK_SEALED. In LK_SEALED, every write is ignored, and LK_SEALED to LK_SEALED is its only transition. Reset enters LK_OPEN.

Top module: `fetch_exec_gate`

## Requirements
- R1: After reset the enable field reads 4'b1001 (false) and the lock reads open (exec_unlocked_o = 1).
- R2: While the lock is open, a write with cfg_sel_i = 0 stores all four bits of cfg_wdata_i into the enable field, and the new value is visible on the cycle after the write.
- R3: A write with cfg_sel_i = 1 and cfg_wdata_i[0] = 0 seals the lock from the next cycle until reset. A lock write with cfg_wdata_i[0] = 1 has no effect.
- R4: While the lock is sealed, writes to the enable field leave it unchanged.
- R5: When fuse_exec_i equals 8'h96, permit_o is 1 exactly when the enable field equals 4'b0110, whatever lc_dbg_i holds.
- R6: When fuse_exec_i is any value other than 8'h96, permit_o is 1 exactly when lc_dbg_i equals 4'b1010, whatever the enable field holds.
- R7: With ExecSupport = 0, permit_o is 0 for every input.
- R8: fetch_req_o equals fetch_req_i AND permit_o, and fetch_err_o equals fetch_req_i AND NOT permit_o, in the same cycle.
- R9: enc_err_o is 1 when any of these holds in that cycle:
  - the enable field is neither 4'b0110 nor 4'b1001;
  - fuse_exec_i is neither 8'h96 nor 8'h69;
  - lc_dbg_i is neither 4'b1010 nor 4'b0101.
  Otherwise enc_err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Write target: 0 selects the enable field, 1 selects the lock |
| cfg_wdata_i | input | 4 | Write data. The lock uses bit 0 only. |
| fuse_exec_i | input | 8 | Multibit fuse execution switch |
| lc_dbg_i | input | 4 | Multibit lifecycle debug-enable |
| fetch_req_i | input | 1 | Instruction-fetch request |
| exec_en_o | output | 4 | Current enable field |
| exec_unlocked_o | output | 1 | 1 while the lock is open |
| permit_o | output | 1 | Fetches are allowed |
| fetch_req_o | output | 1 | Forwarded fetch request |
| fetch_err_o | output | 1 | Error response for a denied fetch |
| enc_err_o | output | 1 | Invalid multibit encoding seen |

## Verification
The assertions assume the following about the inputs:
- every input is a known value at each rising edge;
- a write strobe comes with a defined select and data value;
- the fuse and lifecycle values may change on any cycle.

The stimulus changes inputs only just after a rising edge and holds them through the next edge. It sweeps the fuse and lifecycle codes across true, false and invalid values. The lock is sealed only late in the run, so that writes both before and after sealing are exercised.

// File: rtl/exec_gate_pkg.sv
package exec_gate_pkg;

    localparam int SwW   = 4;
    localparam int FuseW = 8;
    localparam int LcW   = 4;

    localparam logic [SwW-1:0]   SW_TRUE    = 4'b0110;
    localparam logic [SwW-1:0]   SW_FALSE   = 4'b1001;
    localparam logic [FuseW-1:0] FUSE_TRUE  = 8'h96;
    localparam logic [FuseW-1:0] FUSE_FALSE = 8'h69;
    localparam logic [LcW-1:0]   LC_ON      = 4'b1010;
    localparam logic [LcW-1:0]   LC_OFF     = 4'b0101;

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lock_state_e;

endpackage

// File: rtl/mubi_decode.sv
module mubi_decode #(
    parameter int           W       = 4,
    parameter logic [W-1:0] TRUE_V  = '0,
    parameter logic [W-1:0] FALSE_V = '1
) (
    input  logic [W-1:0] val_i,
    output logic         true_o,
    output logic         valid_o
);
    logic is_false;

    always_comb begin
        true_o   = (val_i == TRUE_V);
        is_false = (val_i == FALSE_V);
        valid_o  = true_o | is_false;
    end
endmodule

// File: rtl/exec_lock_reg.sv
module exec_lock_reg
    import exec_gate_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           wr_i,
    input  logic           sel_i,
    input  logic [SwW-1:0] wdata_i,
    output logic [SwW-1:0] en_q_o,
    output logic           open_o
);
    lock_state_e state_q, state_d;
    logic        en_we;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= LK_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        open_o  = 1'b0;
        en_we   = 1'b0;
        unique case (state_q)
            LK_OPEN: begin
                open_o = 1'b1;
                en_we  = wr_i && !sel_i;
                if (wr_i && sel_i && !wdata_i[0]) begin
                    state_d = LK_SEALED;
                end
            end
            LK_SEALED: begin
                state_d = LK_SEALED;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q_o <= SW_FALSE;
        end else if (en_we) begin
            en_q_o <= wdata_i;
        end
    end
endmodule

// File: rtl/fetch_gate.sv
module fetch_gate (
    input  logic permit_i,
    input  logic req_i,
    output logic req_o,
    output logic err_o
);
    always_comb begin
        req_o = req_i & permit_i;
        err_o = req_i & ~permit_i;
    end
endmodule

// File: rtl/fetch_exec_gate.sv
module fetch_exec_gate
    import exec_gate_pkg::*;
#(
    parameter bit ExecSupport = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_wr_i,
    input  logic             cfg_sel_i,
    input  logic [SwW-1:0]   cfg_wdata_i,
    input  logic [FuseW-1:0] fuse_exec_i,
    input  logic [LcW-1:0]   lc_dbg_i,
    input  logic             fetch_req_i,
    output logic [SwW-1:0]   exec_en_o,
    output logic             exec_unlocked_o,
    output logic             permit_o,
    output logic             fetch_req_o,
    output logic             fetch_err_o,
    output logic             enc_err_o
);
    logic sw_true, sw_valid;
    logic fuse_true, fuse_valid;
    logic lc_true, lc_valid;

    exec_lock_reg u_lock (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (cfg_wr_i),
        .sel_i   (cfg_sel_i),
        .wdata_i (cfg_wdata_i),
        .en_q_o  (exec_en_o),
        .open_o  (exec_unlocked_o)
    );

    mubi_decode #(.W(SwW), .TRUE_V(SW_TRUE), .FALSE_V(SW_FALSE)) u_sw_dec (
        .val_i (exec_en_o), .true_o (sw_true), .valid_o (sw_valid)
    );
    mubi_decode #(.W(FuseW), .TRUE_V(FUSE_TRUE), .FALSE_V(FUSE_FALSE)) u_fuse_dec (
        .val_i (fuse_exec_i), .true_o (fuse_true), .valid_o (fuse_valid)
    );
    mubi_decode #(.W(LcW), .TRUE_V(LC_ON), .FALSE_V(LC_OFF)) u_lc_dec (
        .val_i (lc_dbg_i), .true_o (lc_true), .valid_o (lc_valid)
    );

    generate
        if (ExecSupport) begin : g_exec
            always_comb permit_o = fuse_true ? sw_true : lc_true;
        end else begin : g_noexec
            always_comb permit_o = 1'b0;
        end
    endgenerate

    always_comb enc_err_o = ~(sw_valid & fuse_valid & lc_valid);

    fetch_gate u_gate (
        .permit_i (permit_o),
        .req_i    (fetch_req_i),
        .req_o    (fetch_req_o),
        .err_o    (fetch_err_o)
    );
endmodule

// File: rtl/fetch_exec_gate_chk.sv
module fetch_exec_gate_chk #(
    parameter bit ExecSupport = 1'b1
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       cfg_wr_i,
    input logic       cfg_sel_i,
    input logic [3:0] cfg_wdata_i,
    input logic [7:0] fuse_exec_i,
    input logic [3:0] lc_dbg_i,
    input logic       fetch_req_i,
    input logic [3:0] exec_en_o,
    input logic       exec_unlocked_o,
    input logic       permit_o,
    input logic       fetch_req_o,
    input logic       fetch_err_o
);
    a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exec_unlocked_o && cfg_wr_i && !cfg_sel_i) |=> (exec_en_o == $past(cfg_wdata_i)));

    a_r3_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !exec_unlocked_o |=> !exec_unlocked_o);

    a_r4_field_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !exec_unlocked_o |=> $stable(exec_en_o));

    a_r6_lc_decides: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ExecSupport && fuse_exec_i != 8'h96) |-> (permit_o == (lc_dbg_i == 4'b1010)));

    a_r7_no_support: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ExecSupport && fetch_req_i) |-> (fetch_err_o && !permit_o));

    a_r8_fwd_needs_permit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fetch_req_o |-> (fetch_req_i && permit_o && !fetch_err_o));

    a_r8_denied_errs: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fetch_req_i && !permit_o) |-> (fetch_err_o && !fetch_req_o));
endmodule

bind fetch_exec_gate fetch_exec_gate_chk #(.ExecSupport(ExecSupport)) chk_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cfg_wr_i        (cfg_wr_i),
    .cfg_sel_i       (cfg_sel_i),
    .cfg_wdata_i     (cfg_wdata_i),
    .fuse_exec_i     (fuse_exec_i),
    .lc_dbg_i        (lc_dbg_i),
    .fetch_req_i     (fetch_req_i),
    .exec_en_o       (exec_en_o),
    .exec_unlocked_o (exec_unlocked_o),
    .permit_o        (permit_o),
    .fetch_req_o     (fetch_req_o),
    .fetch_err_o     (fetch_err_o)
);

// File: tb/fetch_exec_gate_tb_top.sv
module fetch_exec_gate_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [3:0] cfg_wdata = 4'h0;
    logic [7:0] fuse = 8'h00;
    logic [3:0] lc = 4'b0101;
    logic       freq = 1'b0;

    logic [3:0] en_a, en_b;
    logic       unl_a, unl_b, per_a, per_b, fro_a, fro_b, fer_a, fer_b, enc_a, enc_b;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [3:0] m_en;
    logic       m_lock;

    always #4 clk = ~clk;

    fetch_exec_gate #(.ExecSupport(1'b1)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel),
        .cfg_wdata_i(cfg_wdata), .fuse_exec_i(fuse), .lc_dbg_i(lc), .fetch_req_i(freq),
        .exec_en_o(en_a), .exec_unlocked_o(unl_a), .permit_o(per_a),
        .fetch_req_o(fro_a), .fetch_err_o(fer_a), .enc_err_o(enc_a)
    );

    fetch_exec_gate #(.ExecSupport(1'b0)) dut_noexec_i (
        .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel),
        .cfg_wdata_i(cfg_wdata), .fuse_exec_i(fuse), .lc_dbg_i(lc), .fetch_req_i(freq),
        .exec_en_o(en_b), .exec_unlocked_o(unl_b), .permit_o(per_b),
        .fetch_req_o(fro_b), .fetch_err_o(fer_b), .enc_err_o(enc_b)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en   <= 4'b1001;
            m_lock <= 1'b1;
        end else if (cfg_wr) begin
            if (cfg_sel) begin
                if (!cfg_wdata[0]) m_lock <= 1'b0;
            end else if (m_lock) begin
                m_en <= cfg_wdata;
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic exp_p, exp_enc;
            exp_p = (fuse == 8'h96) ? (m_en == 4'b0110) : (lc == 4'b1010);
            exp_enc = !((m_en == 4'b0110) || (m_en == 4'b1001)) ||
                      !((fuse == 8'h96) || (fuse == 8'h69)) ||
                      !((lc == 4'b1010) || (lc == 4'b0101));
            check(m_lock ? "R2 field" : "R4 field", {4'h0, en_a}, {4'h0, m_en});
            check("R3 lock", {7'h0, unl_a}, {7'h0, m_lock});
            check((fuse == 8'h96) ? "R5 permit" : "R6 permit", {7'h0, per_a}, {7'h0, exp_p});
            check("R8 fwd", {7'h0, fro_a}, {7'h0, freq & exp_p});
            check("R8 err", {7'h0, fer_a}, {7'h0, freq & ~exp_p});
            check("R9 enc", {7'h0, enc_a}, {7'h0, exp_enc});
            check("R7 permit", {7'h0, per_b}, 8'h00);
            check("R7 err", {7'h0, fer_b}, {7'h0, freq});
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic sel, input logic [3:0] d);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        step();
        cfg_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 field", {4'h0, en_a}, 8'h09);
        check("R1 lock", {7'h0, unl_a}, 8'h01);
        step();

        // fuse true: software field decides (R5)
        fuse = 8'h96; lc = 4'b0101; freq = 1'b1;
        step();
        wr(1'b0, 4'b0110);
        step();
        lc = 4'b1010; step();
        lc = 4'b0011; step();
        wr(1'b0, 4'b1001);
        step();
        wr(1'b0, 4'b1111);   // invalid field, R9
        lc = 4'b1010; step();
        wr(1'b0, 4'b0110);
        freq = 1'b0; step();
        freq = 1'b1;

        // fuse not true: lifecycle decides (R6)
        for (int i = 0; i < 16; i++) begin
            fuse = 8'(i * 17);
            lc = (i % 3 == 0) ? 4'b1010 : ((i % 3 == 1) ? 4'b0101 : 4'(i));
            freq = i[0];
            step();
        end
        fuse = 8'h69; lc = 4'b1010; step();
        lc = 4'b0101; step();

        // lock write with bit0 = 1 has no effect (R3)
        wr(1'b1, 4'b0001);
        step();
        wr(1'b0, 4'b1001);
        fuse = 8'h96; step();

        // seal and attempt writes (R3, R4)
        wr(1'b1, 4'b1110);
        step();
        wr(1'b0, 4'b0110);
        step();
        wr(1'b1, 4'b0001);
        wr(1'b0, 4'b0110);
        lc = 4'b1010; step();
        fuse = 8'h00; step();
        repeat (3) step();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule